// File: doc/BRIEF.md
# Fast System Call Entry Unit

This unit works out the processor state that follows a fast system call instruction. A one-cycle request strobe samples the current instruction pointer, the length of the calling instruction, the flags word, the extended-feature enable register, four call-target configuration words and two mode bits. The mode bits say whether long mode is active and whether the caller runs 64-bit code. One cycle later the unit returns one of two results. If system calls are disabled, it raises an invalid-opcode fault. Otherwise it pulses `done_o` and presents the new instruction pointer, the return pointer to be written to the count register, the flags image to be saved in the scratch register, the new flags word, and both segment selectors with their attribute words.

The segment state does not come from a descriptor lookup. It is built from a single base selector taken from the call-target configuration word, and the long-mode and legacy entries differ in the return width, the flag clearing, the target address and the code segment size bits. The surrounding pipeline writes the results into its register file and segment caches when it sees `done_o`.

Top module: `syscall_entry_unit`

## Requirements
- R1: Reset is synchronous and active high. After reset, every output is zero.
- R2: When a request arrives with bit 0 of `efer_i` clear, `fault_o` pulses high for exactly one cycle, one cycle after the request. `fault_err_o` is 0, `done_o` stays low, and every other output keeps its previous value.
- R3: When a request arrives with bit 0 of `efer_i` set, `done_o` pulses high for exactly one cycle, one cycle after the request, and `fault_o` stays low. `done_o` and `fault_o` are never high together, and neither is high unless a request came in the previous cycle.
- R4: `cs_sel_o` is `star_i[47:32]` with bits 1:0 cleared. `ss_sel_o` is `star_i[47:32] + 8`, taken modulo 2^16, with bits 1:0 cleared.
- R5: `seg_base_o` is 0 and `seg_limit_o` is 0xFFFFFFFF after every completed entry.
- R6: The attribute word has these bits: 7 granularity, 6 default-size, 5 long, 4 present, 3 code/data segment, 2 code, 1 readable/writable, 0 accessed. Both segments have bits 7, 4, 3, 1 and 0 set. Only the code segment has bit 2. The stack segment always has bit 6 and never bit 5, so `ss_attr_o` is 0xDB.
- R7: In long mode, `ret_ip_o` is `ip_i + ilen_i` at full 64-bit width. `saved_flags_o` is `flags_i` with the resume flag (bit 16) cleared.
- R8: In long mode, `new_flags_o` is `flags_i` with every bit set in `fmask_i` cleared, and with bit 16 cleared as well.
- R9: In long mode, `new_ip_o` is `lstar_i` when `cs64_i` is set and `cstar_i` otherwise. `cs_attr_o` has bit 5 set and bit 6 clear, so it reads 0xBF.
- R10: In legacy mode, `ret_ip_o` is the low 32 bits of `ip_i + ilen_i`, zero-extended. `new_flags_o` is `flags_i` with bits 9, 16 and 17 cleared. `new_ip_o` is `star_i[31:0]`, zero-extended.
- R11: In legacy mode, `cs_attr_o` has bit 6 set and bit 5 clear, so it reads 0xDF. `saved_flags_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | One-cycle system call request |
| ip_i | input | 64 | Current instruction pointer |
| ilen_i | input | 4 | Length of the calling instruction |
| flags_i | input | 64 | Current flags word |
| efer_i | input | 64 | Extended-feature enable register; bit 0 enables system calls |
| star_i | input | 64 | Legacy target and base selector configuration |
| lstar_i | input | 64 | Target for 64-bit callers |
| cstar_i | input | 64 | Target for compatibility-mode callers |
| fmask_i | input | 64 | Flag bits to clear on long-mode entry |
| lma_i | input | 1 | Long mode active |
| cs64_i | input | 1 | Caller runs 64-bit code |
| done_o | output | 1 | Results valid pulse |
| fault_o | output | 1 | Invalid-opcode fault pulse |
| fault_err_o | output | 16 | Fault error code |
| new_ip_o | output | 64 | New instruction pointer |
| ret_ip_o | output | 64 | Return pointer for the count register |
| saved_flags_o | output | 64 | Flags image for the scratch register |
| new_flags_o | output | 64 | New flags word |
| cs_sel_o | output | 16 | Code segment selector |
| ss_sel_o | output | 16 | Stack segment selector |
| cs_attr_o | output | 8 | Code segment attribute word |
| ss_attr_o | output | 8 | Stack segment attribute word |
| seg_base_o | output | 64 | Base of both segments |
| seg_limit_o | output | 32 | Limit of both segments |

## Verification
Every result is registered only once, so a wrong mode decode or a wrong selector computation shows up at the outputs in the cycle right after the request that caused it. A fault that wrongly updates state shows up as a changed pointer or flags output beside the `fault_o` pulse. A saved-flags register that is loaded on a legacy entry differs from the value left by the last long-mode entry. Back-to-back vectors alternate between modes, so a result left over from the previous entry is caught within one request.

// File: rtl/sce_pkg.sv
package sce_pkg;
  localparam int ATTR_W   = 8;
  localparam int AB_ACC   = 0;
  localparam int AB_RW    = 1;
  localparam int AB_CODE  = 2;
  localparam int AB_SEG   = 3;
  localparam int AB_PRES  = 4;
  localparam int AB_LONG  = 5;
  localparam int AB_DSZ   = 6;
  localparam int AB_GRAN  = 7;
  typedef logic [ATTR_W-1:0] attr_t;

  function automatic attr_t attr_common();
    attr_t a;
    a = '0;
    a[AB_GRAN] = 1'b1;
    a[AB_PRES] = 1'b1;
    a[AB_SEG]  = 1'b1;
    a[AB_RW]   = 1'b1;
    a[AB_ACC]  = 1'b1;
    return a;
  endfunction
endpackage

// File: rtl/sce_selgen.sv
module sce_selgen
  import sce_pkg::*;
#(
  parameter int CFG_W   = 64,
  parameter int SEL_W   = 16,
  parameter int SEL_LSB = 32,
  parameter int SS_STEP = 8
) (
  input  logic [CFG_W-1:0] star_i,
  input  logic             lma_i,
  output logic [SEL_W-1:0] cs_sel_o,
  output logic [SEL_W-1:0] ss_sel_o,
  output attr_t            cs_attr_o,
  output attr_t            ss_attr_o
);
  localparam logic [SEL_W-1:0] RPL_CLR = ~(SEL_W'(3));
  localparam logic [SEL_W-1:0] STEP    = SEL_W'(SS_STEP);

  logic [SEL_W-1:0] base_sel;

  always_comb begin
    base_sel  = star_i[SEL_LSB +: SEL_W];
    cs_sel_o  = base_sel & RPL_CLR;
    ss_sel_o  = (base_sel + STEP) & RPL_CLR;

    cs_attr_o = attr_common();
    cs_attr_o[AB_CODE] = 1'b1;
    cs_attr_o[AB_LONG] = lma_i;
    cs_attr_o[AB_DSZ]  = ~lma_i;

    ss_attr_o = attr_common();
    ss_attr_o[AB_DSZ]  = 1'b1;
  end
endmodule

// File: rtl/sce_target.sv
module sce_target #(
  parameter int ADDR_W = 64,
  parameter int FLG_W  = 64,
  parameter int ILEN_W = 4,
  parameter int LEG_W  = 32,
  parameter int IF_BIT = 9,
  parameter int RF_BIT = 16,
  parameter int VM_BIT = 17
) (
  input  logic [ADDR_W-1:0] ip_i,
  input  logic [ILEN_W-1:0] ilen_i,
  input  logic [FLG_W-1:0]  flags_i,
  input  logic [ADDR_W-1:0] star_i,
  input  logic [ADDR_W-1:0] lstar_i,
  input  logic [ADDR_W-1:0] cstar_i,
  input  logic [FLG_W-1:0]  fmask_i,
  input  logic              lma_i,
  input  logic              cs64_i,
  output logic [ADDR_W-1:0] new_ip_o,
  output logic [ADDR_W-1:0] ret_ip_o,
  output logic [FLG_W-1:0]  saved_flags_o,
  output logic [FLG_W-1:0]  new_flags_o
);
  localparam logic [FLG_W-1:0] RF_M = FLG_W'(1) << RF_BIT;
  localparam logic [FLG_W-1:0] LEG_CLR =
      (FLG_W'(1) << IF_BIT) | (FLG_W'(1) << RF_BIT) | (FLG_W'(1) << VM_BIT);

  logic [ADDR_W-1:0] next_ip;
  logic [ADDR_W-1:0] leg_ret;
  logic [ADDR_W-1:0] leg_tgt;

  always_comb begin
    next_ip = ip_i + ADDR_W'(ilen_i);
    leg_ret = ADDR_W'(next_ip[LEG_W-1:0]);
    leg_tgt = ADDR_W'(star_i[LEG_W-1:0]);
    saved_flags_o = flags_i & ~RF_M;
    if (lma_i) begin
      ret_ip_o    = next_ip;
      new_flags_o = flags_i & ~(fmask_i | RF_M);
      new_ip_o    = cs64_i ? lstar_i : cstar_i;
    end else begin
      ret_ip_o    = leg_ret;
      new_flags_o = flags_i & ~LEG_CLR;
      new_ip_o    = leg_tgt;
    end
  end
endmodule

// File: rtl/syscall_entry_unit.sv
module syscall_entry_unit
  import sce_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int FLG_W   = 64,
  parameter int ILEN_W  = 4,
  parameter int SEL_W   = 16,
  parameter int ERR_W   = 16,
  parameter int LIM_W   = 32,
  parameter int SCE_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] ip_i,
  input  logic [ILEN_W-1:0] ilen_i,
  input  logic [FLG_W-1:0]  flags_i,
  input  logic [63:0]       efer_i,
  input  logic [ADDR_W-1:0] star_i,
  input  logic [ADDR_W-1:0] lstar_i,
  input  logic [ADDR_W-1:0] cstar_i,
  input  logic [FLG_W-1:0]  fmask_i,
  input  logic              lma_i,
  input  logic              cs64_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [ERR_W-1:0]  fault_err_o,
  output logic [ADDR_W-1:0] new_ip_o,
  output logic [ADDR_W-1:0] ret_ip_o,
  output logic [FLG_W-1:0]  saved_flags_o,
  output logic [FLG_W-1:0]  new_flags_o,
  output logic [SEL_W-1:0]  cs_sel_o,
  output logic [SEL_W-1:0]  ss_sel_o,
  output logic [ATTR_W-1:0] cs_attr_o,
  output logic [ATTR_W-1:0] ss_attr_o,
  output logic [ADDR_W-1:0] seg_base_o,
  output logic [LIM_W-1:0]  seg_limit_o
);
  logic [SEL_W-1:0]  c_cs_sel, c_ss_sel;
  attr_t             c_cs_attr, c_ss_attr;
  logic [ADDR_W-1:0] c_new_ip, c_ret_ip;
  logic [FLG_W-1:0]  c_saved, c_new_flags;
  logic              enabled;

  assign enabled = efer_i[SCE_BIT];

  sce_selgen #(.CFG_W(ADDR_W), .SEL_W(SEL_W)) u_sel (
    .star_i   (star_i),
    .lma_i    (lma_i),
    .cs_sel_o (c_cs_sel),
    .ss_sel_o (c_ss_sel),
    .cs_attr_o(c_cs_attr),
    .ss_attr_o(c_ss_attr)
  );

  sce_target #(.ADDR_W(ADDR_W), .FLG_W(FLG_W), .ILEN_W(ILEN_W)) u_tgt (
    .ip_i         (ip_i),
    .ilen_i       (ilen_i),
    .flags_i      (flags_i),
    .star_i       (star_i),
    .lstar_i      (lstar_i),
    .cstar_i      (cstar_i),
    .fmask_i      (fmask_i),
    .lma_i        (lma_i),
    .cs64_i       (cs64_i),
    .new_ip_o     (c_new_ip),
    .ret_ip_o     (c_ret_ip),
    .saved_flags_o(c_saved),
    .new_flags_o  (c_new_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o        <= 1'b0;
      fault_o       <= 1'b0;
      fault_err_o   <= '0;
      new_ip_o      <= '0;
      ret_ip_o      <= '0;
      saved_flags_o <= '0;
      new_flags_o   <= '0;
      cs_sel_o      <= '0;
      ss_sel_o      <= '0;
      cs_attr_o     <= '0;
      ss_attr_o     <= '0;
      seg_base_o    <= '0;
      seg_limit_o   <= '0;
    end else begin
      done_o  <= req_i & enabled;
      fault_o <= req_i & ~enabled;
      if (req_i && !enabled) begin
        fault_err_o <= '0;
      end
      if (req_i && enabled) begin
        new_ip_o    <= c_new_ip;
        ret_ip_o    <= c_ret_ip;
        new_flags_o <= c_new_flags;
        cs_sel_o    <= c_cs_sel;
        ss_sel_o    <= c_ss_sel;
        cs_attr_o   <= c_cs_attr;
        ss_attr_o   <= c_ss_attr;
        seg_base_o  <= '0;
        seg_limit_o <= '1;
        if (lma_i) begin
          saved_flags_o <= c_saved;
        end
      end
    end
  end

  assert_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(done_o && fault_o));
  assert_done_needs_req_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(req_i) && $past(efer_i[SCE_BIT]));
  assert_fault_needs_off_R2: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> $past(req_i) && !$past(efer_i[SCE_BIT]));
  assert_fault_holds_R2: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> $stable(new_ip_o) && $stable(new_flags_o) && $stable(cs_sel_o));
  assert_ss_follows_cs_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ss_sel_o == cs_sel_o + SEL_W'(8));
  assert_long_attr_R9: assert property (@(posedge clk) disable iff (rst)
    done_o && $past(lma_i) |-> cs_attr_o[AB_LONG] && !cs_attr_o[AB_DSZ]);
  assert_leg_attr_R11: assert property (@(posedge clk) disable iff (rst)
    done_o && !$past(lma_i) |-> !cs_attr_o[AB_LONG] && cs_attr_o[AB_DSZ]);
  assert_ss_attr_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ss_attr_o[AB_PRES] && ss_attr_o[AB_RW] && !ss_attr_o[AB_CODE]);
endmodule

// File: tb/syscall_entry_unit_test.sv
`timescale 1ns/1ps
module syscall_entry_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_i = 1'b0;
  logic [63:0] ip_i = '0;
  logic [3:0]  ilen_i = '0;
  logic [63:0] flags_i = '0, efer_i = '0, star_i = '0;
  logic [63:0] lstar_i = 64'hFFFF_8000_0010_0000;
  logic [63:0] cstar_i = 64'h0000_0000_C020_3000;
  logic [63:0] fmask_i = 64'h0000_0000_0004_0700;
  logic        lma_i = 1'b0, cs64_i = 1'b0;
  logic        done_o, fault_o;
  logic [15:0] fault_err_o, cs_sel_o, ss_sel_o;
  logic [63:0] new_ip_o, ret_ip_o, saved_flags_o, new_flags_o, seg_base_o;
  logic [7:0]  cs_attr_o, ss_attr_o;
  logic [31:0] seg_limit_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [63:0] exp_saved = '0;

  always #10 clk = ~clk;

  syscall_entry_unit uut (.*);

  typedef struct packed {
    logic        en;
    logic        lma;
    logic        c64;
    logic [3:0]  ilen;
    logic [63:0] ip;
    logic [63:0] flags;
    logic [63:0] star;
    logic [63:0] exp_ip;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VT [NV] = '{
    '{1'b1, 1'b1, 1'b1, 4'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0003_0746,
      64'h0023_0010_1234_5678, 64'hFFFF_8000_0010_0000},
    '{1'b1, 1'b0, 1'b0, 4'd2, 64'h0000_0001_FFFF_FFFF, 64'h0000_0000_0003_0202,
      64'h001B_0013_8000_1000, 64'h0000_0000_8000_1000},
    '{1'b1, 1'b1, 1'b0, 4'd3, 64'h0000_0000_0040_1000, 64'h0000_0000_0001_0002,
      64'h0000_FFFE_0000_0000, 64'h0000_0000_C020_3000},
    '{1'b1, 1'b0, 1'b1, 4'd15, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_0002,
      64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF},
    '{1'b1, 1'b1, 1'b1, 4'd0, 64'h0000_7FFF_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
      64'h0000_0008_0000_0000, 64'hFFFF_8000_0010_0000},
    '{1'b1, 1'b0, 1'b0, 4'd1, 64'h0000_0000_0000_0000, 64'h0000_0000_0002_0200,
      64'h0000_0003_0000_0004, 64'h0000_0000_0000_0004}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fire(input vec_t v);
    @(negedge clk);
    efer_i = {63'd0, v.en};
    lma_i = v.lma; cs64_i = v.c64; ilen_i = v.ilen;
    ip_i = v.ip; flags_i = v.flags; star_i = v.star;
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic check_entry(input vec_t v);
    logic [63:0] nx, ret, nf;
    logic [15:0] b;
    nx = v.ip + {60'd0, v.ilen};
    b  = v.star[47:32];
    chk("R3 done", {63'd0, done_o}, 64'd1);
    chk("R3 no fault", {63'd0, fault_o}, 64'd0);
    chk("R4 cs_sel", {48'd0, cs_sel_o}, {48'd0, b & 16'hFFFC});
    chk("R4 ss_sel", {48'd0, ss_sel_o}, {48'd0, (b + 16'd8) & 16'hFFFC});
    chk("R5 base", seg_base_o, 64'd0);
    chk("R5 limit", {32'd0, seg_limit_o}, 64'hFFFF_FFFF);
    chk("R6 ss_attr", {56'd0, ss_attr_o}, 64'hDB);
    if (v.lma) begin
      ret = nx;
      nf  = v.flags & ~(fmask_i | 64'h1_0000);
      exp_saved = v.flags & ~64'h1_0000;
      chk("R7 ret", ret_ip_o, ret);
      chk("R7 saved", saved_flags_o, exp_saved);
      chk("R8 flags", new_flags_o, nf);
      chk("R9 ip", new_ip_o, v.exp_ip);
      chk("R9 cs_attr", {56'd0, cs_attr_o}, 64'hBF);
    end else begin
      ret = {32'd0, nx[31:0]};
      nf  = v.flags & ~64'h3_0200;
      chk("R10 ret", ret_ip_o, ret);
      chk("R10 flags", new_flags_o, nf);
      chk("R10 ip", new_ip_o, v.exp_ip);
      chk("R11 cs_attr", {56'd0, cs_attr_o}, 64'hDF);
      chk("R11 saved hold", saved_flags_o, exp_saved);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t f;
    logic [63:0] held_ip, held_flags;
    logic [15:0] held_cs;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", {63'd0, done_o}, 64'd0);
    chk("R1 fault", {63'd0, fault_o}, 64'd0);
    chk("R1 ip", new_ip_o, 64'd0);
    chk("R1 cs_attr", {56'd0, cs_attr_o}, 64'd0);
    chk("R1 limit", {32'd0, seg_limit_o}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      fire(VT[i]);
      check_entry(VT[i]);
      @(negedge clk);
      chk("R3 one-cycle done", {63'd0, done_o}, 64'd0);
    end

    // R2: disabled system calls fault and leave state alone
    held_ip = new_ip_o; held_flags = new_flags_o; held_cs = cs_sel_o;
    f = VT[0];
    f.en = 1'b0;
    f.star = 64'h0040_0000_DEAD_BEEF;
    f.flags = 64'h0;
    fire(f);
    chk("R2 fault", {63'd0, fault_o}, 64'd1);
    chk("R2 no done", {63'd0, done_o}, 64'd0);
    chk("R2 err", {48'd0, fault_err_o}, 64'd0);
    chk("R2 ip hold", new_ip_o, held_ip);
    chk("R2 flags hold", new_flags_o, held_flags);
    chk("R2 cs hold", {48'd0, cs_sel_o}, {48'd0, held_cs});
    chk("R2 saved hold", saved_flags_o, exp_saved);
    @(negedge clk);
    chk("R2 one-cycle fault", {63'd0, fault_o}, 64'd0);

    // R3: no request, no pulse
    repeat (3) @(negedge clk);
    chk("R3 idle", {62'd0, done_o, fault_o}, 64'd0);

    // R1 again: reset clears results
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ret cleared", ret_ip_o, 64'd0);
    chk("R1 saved cleared", saved_flags_o, 64'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule